// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is a timer built around an up-counter (16 bits by default) that is paired with a compare register, one output pin and one external event input. The event input arrives already edge-qualified, as a pulse one clock wide. A 3-bit mode value sets two things at once. The first is what restarts the counter: nothing, an external event, or a compare match. The second is what drives the output pin: a PWM waveform, toggling on compare match, or toggling on compare match or an external event.

The counter advances once per clock while the timer runs. In every running cycle where the count equals the compare value, the block raises a match pulse. A rollover from all ones to zero sets a sticky overflow flag. This includes the rollover produced by a compare clear when the compare value is all ones. The flag stays set until software clears it. A mode change is only accepted from the stopped state or when the new value is the stop code. Software therefore has to stop the timer before it changes the clear source or the output source.

Top module: `evt_timer16`

## Requirements
- R1: In mode 000 (stopped) the count is zero from the next cycle on, the match pulse stays low and the toggle state of the output holds.
- R2: In modes 001, 010 and 011 the count rises by one every cycle and wraps from all ones to zero. External events do not change the count.
- R3: In modes 100 and 101 an external event pulse makes the count zero in the next cycle instead of incrementing it.
- R4: In modes 110 and 111 a cycle where the count equals the compare value is followed by a count of zero.
- R5: In mode 001 the output is high while the count is below the compare value and low otherwise.
- R6: In modes 010, 100 and 110 the output toggles in the cycle after a compare match. In modes 011, 101 and 111 it toggles after a match or an external event, and a match and an event in the same cycle give a single toggle.
- R7: The overflow flag sets in the cycle after a running count equals all ones, whether the count then increments or is cleared. It stays set until `ovf_clr` is high, and a set in the same cycle as a clear wins.
- R8: `match_o` is high exactly in the cycles where the mode is not 000 and the count equals the compare value.
- R9: A mode write takes effect in the next cycle only if the current mode is 000 or the written value is 000. Any other write is ignored.
- R10: After reset the mode is 000, the count, the compare value and the output are zero, and the overflow flag is clear.
- R11: A compare write is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode value to write |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare value to write |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_evt | input | 1 | Qualified external event, one cycle wide |
| count_o | output | CNT_W | Current count |
| match_o | output | 1 | Count equals compare while running |
| ovf_o | output | 1 | Sticky overflow flag |
| out_o | output | 1 | Timer output pin |

## Verification
A wrong count is visible on `count_o` in the first cycle after the fault. It also shifts every later match, so a bad clear source shows up at once as a count that fails to drop to zero. A corrupted toggle state or a mis-decoded output source shows on `out_o` one cycle after the event that should or should not have flipped it. Overflow faults only become visible at a rollover, so the bench drives full 65536-cycle wraps. One wrap is in clear-on-match mode with an all-ones compare value. The other is in PWM mode with the clear input held high, which tests that a set wins over a clear.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   typedef enum logic [2:0] {
      MD_STOP     = 3'b000,
      MD_PWM      = 3'b001,
      MD_FREE_M   = 3'b010,
      MD_FREE_ME  = 3'b011,
      MD_EXTCLR_M = 3'b100,
      MD_EXTCLR_ME= 3'b101,
      MD_CMPCLR_M = 3'b110,
      MD_CMPCLR_ME= 3'b111
   } tmr_mode_e;

   // decoded control lines, one per behaviour the mode selects
   typedef struct packed {
      logic run;
      logic pwm;
      logic clr_on_ext;
      logic clr_on_cmp;
      logic tog_en;
      logic tog_on_ext;
   } tmr_ctl_t;

   function automatic tmr_ctl_t decode_mode(input tmr_mode_e m);
      tmr_ctl_t c;
      c.run        = (m != MD_STOP);
      c.pwm        = (m == MD_PWM);
      c.clr_on_ext = (m == MD_EXTCLR_M) || (m == MD_EXTCLR_ME);
      c.clr_on_cmp = (m == MD_CMPCLR_M) || (m == MD_CMPCLR_ME);
      c.tog_en     = m[2] | m[1];
      c.tog_on_ext = c.tog_en & m[0];
      return c;
   endfunction

endpackage

// File: rtl/tmr16_mode_reg.sv
module tmr16_mode_reg
   import tmr16_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr,
   input  logic [2:0] wdata,
   output tmr_mode_e mode_q,
   output tmr_ctl_t  ctl
);

   logic accept;

   // change only from stop, or toward stop
   assign accept = wr && ((mode_q == MD_STOP) || (wdata == 3'b000));

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= MD_STOP;
      else if (accept)
         mode_q <= tmr_mode_e'(wdata);
   end

   assign ctl = decode_mode(mode_q);

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
   import tmr16_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_ctl_t         ctl,
   input  logic [CNT_W-1:0] cmp,
   input  logic             ext_evt,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count_q,
   output logic             hit,
   output logic             ovf_q
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic clr;
   logic at_max;

   assign hit    = ctl.run && (count_q == cmp);
   assign clr    = (ctl.clr_on_ext && ext_evt) || (ctl.clr_on_cmp && hit);
   assign at_max = ctl.run && (count_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n)
         count_q <= '0;
      else if (!ctl.run || clr)
         count_q <= '0;
      else
         count_q <= count_q + 1'b1;
   end

   // next value from all ones is zero whichever path is taken
   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (at_max)
         ovf_q <= 1'b1;
      else if (ovf_clr)
         ovf_q <= 1'b0;
   end

endmodule

// File: rtl/tmr16_outgen.sv
module tmr16_outgen
   import tmr16_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit PWM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_ctl_t         ctl,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp,
   input  logic             hit,
   input  logic             ext_evt,
   output logic             out
);

   logic tog_q;
   logic tog_evt;

   assign tog_evt = ctl.tog_en && (hit || (ctl.tog_on_ext && ext_evt));

   always_ff @(posedge clk) begin
      if (!rst_n)
         tog_q <= 1'b0;
      else if (tog_evt)
         tog_q <= ~tog_q;
   end

   generate
      if (PWM_EN) begin : g_pwm
         logic pwm_lvl;
         assign pwm_lvl = (count < cmp);
         assign out     = ctl.pwm ? pwm_lvl : tog_q;
      end else begin : g_nopwm
         assign out = tog_q;
      end
   endgenerate

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
   import tmr16_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit PWM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [2:0]       mode_wdata,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             ovf_clr,
   input  logic             ext_evt,
   output logic [CNT_W-1:0] count_o,
   output logic             match_o,
   output logic             ovf_o,
   output logic             out_o
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("evt_timer16: CNT_W out of range 2..32");
      end
   endgenerate

   tmr_mode_e        mode_q;
   tmr_ctl_t         ctl;
   logic [CNT_W-1:0] cmp_q;
   logic             hit;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cmp_q <= '0;
      else if (cmp_wr)
         cmp_q <= cmp_wdata;
   end

   tmr16_mode_reg u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (mode_wr),
      .wdata  (mode_wdata),
      .mode_q (mode_q),
      .ctl    (ctl)
   );

   tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl),
      .cmp     (cmp_q),
      .ext_evt (ext_evt),
      .ovf_clr (ovf_clr),
      .count_q (count_o),
      .hit     (hit),
      .ovf_q   (ovf_o)
   );

   tmr16_outgen #(.CNT_W(CNT_W), .PWM_EN(PWM_EN)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl),
      .count   (count_o),
      .cmp     (cmp_q),
      .hit     (hit),
      .ext_evt (ext_evt),
      .out     (out_o)
   );

   assign match_o = hit;

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       mode,
   input logic             mode_wr,
   input logic [2:0]       mode_wdata,
   input logic [CNT_W-1:0] count,
   input logic             match,
   input logic             ovf,
   input logic             ovf_clr,
   input logic             ext_evt
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   // R1
   stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b000) |=> (count == '0));

   // R2
   free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 3'b001 || mode == 3'b010 || mode == 3'b011) && count != CMAX && !mode_wr)
      |=> (count == CNT_W'($past(count) + 1'b1)));

   // R3
   ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2:1] == 2'b10 && ext_evt) |=> (count == '0));

   // R4
   cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2:1] == 2'b11 && match) |=> (count == '0));

   // R7
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 3'b000 && count == CMAX) |=> ovf);

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);

   // R8
   match_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> (mode != 3'b000));

   // R9
   mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 3'b000 && mode_wr && mode_wdata != 3'b000) |=> $stable(mode));

endmodule

bind evt_timer16 tmr16_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode_q),
   .mode_wr    (mode_wr),
   .mode_wdata (mode_wdata),
   .count      (count_o),
   .match      (match_o),
   .ovf        (ovf_o),
   .ovf_clr    (ovf_clr),
   .ext_evt    (ext_evt)
);

// File: tb/evt_timer16_tb.sv
module evt_timer16_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [2:0]  mode_wdata = 3'b000;
   logic        cmp_wr = 1'b0;
   logic [15:0] cmp_wdata = 16'h0;
   logic        ovf_clr = 1'b0;
   logic        ext_evt = 1'b0;
   logic [15:0] count_o;
   logic        match_o;
   logic        ovf_o;
   logic        out_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   evt_timer16 u_dut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ovf_clr(ovf_clr), .ext_evt(ext_evt),
      .count_o(count_o), .match_o(match_o), .ovf_o(ovf_o), .out_o(out_o)
   );

   // behavioural reference state
   int m_mode = 0;
   int m_count = 0;
   int m_cmp = 0;
   bit m_tog = 0;
   bit m_ovf = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_count = 0; m_cmp = 0; m_tog = 0; m_ovf = 0;
      end else begin
         bit run, mt, clr, tg;
         run = (m_mode != 0);
         mt  = run && (m_count == m_cmp);
         clr = ((m_mode == 4 || m_mode == 5) && ext_evt) || (m_mode >= 6 && mt);
         tg  = (m_mode >= 2) && (mt || ((m_mode % 2 == 1) && ext_evt));
         if (run && m_count == 65535) m_ovf = 1;
         else if (ovf_clr) m_ovf = 0;
         if (tg) m_tog = !m_tog;
         if (!run || clr) m_count = 0;
         else m_count = (m_count + 1) % 65536;
         if (cmp_wr) m_cmp = int'(cmp_wdata);
         if (mode_wr && (m_mode == 0 || mode_wdata == 3'b000)) m_mode = int'(mode_wdata);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e_match, e_out;
         string tc, to;
         e_match = (m_mode != 0) && (m_count == m_cmp);
         e_out   = (m_mode == 1) ? (m_count < m_cmp) : m_tog;
         tc = (m_mode == 0) ? "R1 count" : (m_mode <= 3) ? "R2 count" :
              (m_mode <= 5) ? "R3 count" : "R4 count";
         to = (m_mode == 1) ? "R5 pwm out" : "R6 toggle out";
         check(tc, int'(count_o), m_count);
         check(to, int'(out_o), int'(e_out));
         check("R8 match", int'(match_o), int'(e_match));
         check("R7 overflow", int'(ovf_o), int'(m_ovf));
      end
   end

   task automatic wr_mode(input logic [2:0] m);
      @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic wr_cmp(input logic [15:0] v);
      @(negedge clk); cmp_wr = 1'b1; cmp_wdata = v;
      @(negedge clk); cmp_wr = 1'b0;
   endtask

   task automatic run(input int n, input int pct);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ext_evt = (($urandom % 100) < pct);
      end
      @(negedge clk); ext_evt = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: values held during reset
      check("R10 count", int'(count_o), 0);
      check("R10 out", int'(out_o), 0);
      check("R10 ovf", int'(ovf_o), 0);
      check("R10 match", int'(match_o), 0);
      rst_n = 1'b1;

      // R1: stopped, events have no effect
      run(40, 30);

      // R11 / R2 / R6: free running with match-only toggle
      wr_cmp(16'd20);
      wr_mode(3'b010);
      run(150, 20);

      // R9: attempt to switch while running is ignored
      wr_mode(3'b110);
      run(40, 0);
      check("R9 count past cmp", int'(count_o > 16'd20), 1);

      wr_mode(3'b000);
      run(5, 50);
      wr_mode(3'b011);
      run(150, 15);

      wr_mode(3'b000);
      wr_mode(3'b100);
      run(300, 8);
      wr_mode(3'b000);
      wr_mode(3'b101);
      run(300, 8);

      wr_mode(3'b000);
      wr_cmp(16'd30);
      wr_mode(3'b110);
      run(200, 10);
      wr_cmp(16'd7);
      run(60, 10);
      wr_mode(3'b000);
      wr_mode(3'b111);
      run(200, 25);

      // R4 / R7: clear-on-match with all-ones compare, then sticky flag
      wr_mode(3'b000);
      wr_cmp(16'hFFFF);
      wr_mode(3'b110);
      run(65545, 0);
      check("R7 sticky set", int'(ovf_o), 1);
      run(20, 0);
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
      check("R7 cleared", int'(ovf_o), 0);

      // R5 / R7: PWM wrap while clear is held, set must win
      wr_mode(3'b000);
      wr_mode(3'b001);
      wr_cmp(16'h8000);
      @(negedge clk); ovf_clr = 1'b1;
      run(65545, 10);
      @(negedge clk); ovf_clr = 1'b0;
      run(40, 0);

      wr_mode(3'b000);
      run(10, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule